// File: doc/BRIEF.md
# Serial memory command front-end

This block sits behind the pins of a serial non-volatile memory and handles the first byte of every bus transaction. While the active-low select is held low it takes one bit from the serial data input on each rising edge of the serial clock, most significant bit first. After the eighth bit it decodes the instruction and raises a one-cycle execute strobe together with the decoded operation. It also keeps the write enable latch, which must be armed before any array program or status-register write. A hardware write-protect pin overrides that latch.

The address and data phases, the memory array and the programming timer sit outside this block. The downstream logic reports the arrival of the final data bit on `lastDataBit` and the progress of a program cycle on `progBusy`. In return the block issues `progStart` only when programming is allowed at that moment. It drives the status byte during a status read. Two cases make it stop acting on the bus until the next select: an unsupported opcode, which also drops its internal selection, and a write-enable or write-disable instruction that has completed. The serial output is enabled only while a status read is in progress.

All inputs are taken as synchronous to `clk`. The serial clock must stay at each level for at least one `clk` cycle so that the block can see its edges.

Top module: `spi_mem_cmd_frontend`

## Requirements
- R1: After reset `wel`, `execStb`, `progStart` and `serOutEn` are 0 and `opKind` is 0 (none).
- R2: While `selN` is low, `serIn` is captured on each rising edge of `serClk`, most significant bit first. After the eighth edge of a supported opcode, `execStb` is high for exactly one `clk` cycle and `opKind` shows the operation until `selN` rises.
- R3: Bit 3 of the opcode is ignored. With it cleared, 0x06 is write-enable (`opKind`=1), 0x04 is write-disable (2), 0x05 is status read (3), 0x01 is status write (4), 0x03 is array read (5) and 0x02 is array write (6). Every other value is unsupported.
- R4: `addrMsb` equals opcode bit 3 for array read and array write, and is 0 for every other operation.
- R5: An unsupported opcode produces no `execStb`, drives `devSelected` low and makes the block ignore the serial clock until `selN` has been high again.
- R6: A write-enable instruction sets `wel` and a write-disable instruction clears it.
- R7: After a write-enable or write-disable, further serial clocks in the same selection decode nothing.
- R8: While `wpN` is low, `wel` is cleared and a write-enable does not set it. `progPermit` is high exactly when `wel` is high and `wpN` is high.
- R9: In an array write or status write, `lastDataBit` with `wel` set and `wpN` high gives a single `progStart` pulse on the next cycle and then clears `wel`. With `wel` clear it gives no pulse.
- R10: If `wpN` goes low at any time after the opcode and before `lastDataBit`, no `progStart` follows and `wel` stays cleared.
- R11: During a status read the block drives the byte {000000, `wel`, `progBusy`} on `serOut`, most significant bit first. A new bit appears after each falling serial clock edge, starting with the falling edge that follows the eighth opcode bit, and the byte repeats every eight bits.
- R12: `serOutEn` is high only during a status read, and it is low from the first `clk` cycle after `selN` goes high.
- R13: Raising `selN` discards a partly shifted opcode, so the next selection decodes a fresh byte.
- R14: In an array read or status read, `lastDataBit` produces no `progStart` and leaves `wel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, power-on |
| selN | input | 1 | Active-low bus select |
| serClk | input | 1 | Serial bus clock |
| serIn | input | 1 | Serial data into the device |
| wpN | input | 1 | Active-low hardware write protect |
| lastDataBit | input | 1 | Pulse from data phase: final data bit shifted in |
| progBusy | input | 1 | Programming cycle in progress, reported in status |
| serOut | output | 1 | Serial data out of the device |
| serOutEn | output | 1 | Output enable for serOut |
| execStb | output | 1 | One-cycle strobe on a decoded supported opcode |
| opKind | output | 3 | Decoded operation code (see R3) |
| addrMsb | output | 1 | Top address bit taken from the opcode |
| wel | output | 1 | Write enable latch state |
| progPermit | output | 1 | Programming currently allowed |
| progStart | output | 1 | One-cycle request to begin programming |
| devSelected | output | 1 | Internal selection, low when deselected or halted |

## Verification
The assertions assume that `lastDataBit` is a single-cycle pulse. They also assume that every serial clock level lasts at least one `clk` cycle, so that rising and falling edges never share a cycle, and that all inputs change synchronously. The bench drives inputs only on the falling edge of `clk` and holds each serial clock phase for two cycles. It raises `lastDataBit` for exactly one cycle, and only during a selection. Write-protect changes are placed between serial edges, never on them.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam int OP_W = 8;
  localparam int ADDR_BIT = 3;
  localparam logic [OP_W-1:0] OPC_MASK = ~(OP_W'(1) << ADDR_BIT);

  localparam logic [OP_W-1:0] OPC_WREN  = 8'h06;
  localparam logic [OP_W-1:0] OPC_WRDI  = 8'h04;
  localparam logic [OP_W-1:0] OPC_RDSR  = 8'h05;
  localparam logic [OP_W-1:0] OPC_WRSR  = 8'h01;
  localparam logic [OP_W-1:0] OPC_READ  = 8'h03;
  localparam logic [OP_W-1:0] OPC_WRITE = 8'h02;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_RDSR  = 3'd3,
    OP_WRSR  = 3'd4,
    OP_READ  = 3'd5,
    OP_WRITE = 3'd6
  } opKind_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_WAIT,
    ST_HALT,
    ST_STAT,
    ST_ARRAY,
    ST_PROG
  } ctlState_e;

  typedef struct packed {
    logic clrShift;
    logic shiftIn;
    logic clrOut;
    logic loadStat;
    logic shiftOut;
  } dpStrobe_t;
endpackage

// File: rtl/cmdfe_dpath.sv
module cmdfe_dpath
  import cmdfe_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic            serIn,
  input  logic [OP_W-1:0] statusWord,
  output opKind_e         decOp,
  output logic            decAddr,
  output logic            serOut
);
  logic [OP_W-1:0] shReg;
  logic [OP_W-1:0] nextByte;
  logic [OP_W-1:0] maskedByte;
  logic [OP_W-1:0] outReg;

  // Byte as it will stand once the current bit is taken
  assign nextByte   = {shReg[OP_W-2:0], serIn};
  assign maskedByte = nextByte & OPC_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.clrShift) begin
      shReg <= '0;
    end else if (strobe.shiftIn) begin
      shReg <= nextByte;
    end
  end

  always_comb begin
    case (maskedByte)
      OPC_WREN:  decOp = OP_WREN;
      OPC_WRDI:  decOp = OP_WRDI;
      OPC_RDSR:  decOp = OP_RDSR;
      OPC_WRSR:  decOp = OP_WRSR;
      OPC_READ:  decOp = OP_READ;
      OPC_WRITE: decOp = OP_WRITE;
      default:   decOp = OP_NONE;
    endcase
  end

  assign decAddr = nextByte[ADDR_BIT] & ((decOp == OP_READ) || (decOp == OP_WRITE));

  // Status output shifter, reloaded every OP_W bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobe.clrOut) begin
      outReg <= '0;
    end else if (strobe.loadStat) begin
      outReg <= statusWord;
    end else if (strobe.shiftOut) begin
      outReg <= {outReg[OP_W-2:0], 1'b0};
    end
  end

  assign serOut = outReg[OP_W-1];
endmodule

// File: rtl/cmdfe_ctrl.sv
module cmdfe_ctrl
  import cmdfe_pkg::*;
#(
  parameter int CNT_W = $clog2(OP_W)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selN,
  input  logic      serClk,
  input  logic      wpN,
  input  logic      lastDataBit,
  input  opKind_e   decOp,
  input  logic      decAddr,
  output dpStrobe_t strobe,
  output logic      execStb,
  output opKind_e   opKind,
  output logic      addrMsb,
  output logic      wel,
  output logic      progStart,
  output logic      serOutEn,
  output logic      devSelected
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OP_W - 1);

  ctlState_e        state;
  logic             sclkQ;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] outCnt;
  logic             clkRise;
  logic             clkFall;
  logic             inCmd;
  logic             lastBit;
  logic             dataEnd;

  assign clkRise = serClk & ~sclkQ;
  assign clkFall = ~serClk & sclkQ;
  assign inCmd   = !selN && (state == ST_CMD);
  assign lastBit = inCmd && clkRise && (bitCnt == LAST_CNT);
  assign dataEnd = !selN && (state == ST_PROG) && lastDataBit;

  always_comb begin
    strobe.clrShift = selN;
    strobe.shiftIn  = inCmd && clkRise;
    strobe.clrOut   = selN;
    strobe.loadStat = !selN && (state == ST_STAT) && clkFall && (outCnt == '0);
    strobe.shiftOut = !selN && (state == ST_STAT) && clkFall && (outCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
    end else begin
      sclkQ <= serClk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      outCnt  <= '0;
      opKind  <= OP_NONE;
      addrMsb <= 1'b0;
      execStb <= 1'b0;
    end else begin
      execStb <= 1'b0;
      if (selN) begin
        state   <= ST_CMD;
        bitCnt  <= '0;
        outCnt  <= '0;
        opKind  <= OP_NONE;
        addrMsb <= 1'b0;
      end else begin
        case (state)
          ST_CMD: begin
            if (clkRise) begin
              bitCnt <= bitCnt + 1'b1;
            end
            if (lastBit) begin
              execStb <= (decOp != OP_NONE);
              opKind  <= decOp;
              addrMsb <= decAddr;
              case (decOp)
                OP_WREN, OP_WRDI: state <= ST_WAIT;
                OP_RDSR:          state <= ST_STAT;
                OP_READ:          state <= ST_ARRAY;
                OP_WRSR, OP_WRITE: state <= ST_PROG;
                default:          state <= ST_HALT;
              endcase
            end
          end
          ST_STAT: begin
            if (clkFall) begin
              outCnt <= outCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Write enable latch: protect pin has top priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (!wpN) begin
      wel <= 1'b0;
    end else if (lastBit && (decOp == OP_WREN)) begin
      wel <= 1'b1;
    end else if (lastBit && (decOp == OP_WRDI)) begin
      wel <= 1'b0;
    end else if (dataEnd) begin
      wel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progStart <= 1'b0;
    end else begin
      progStart <= dataEnd && wel && wpN;
    end
  end

  assign serOutEn    = (state == ST_STAT);
  assign devSelected = !selN && (state != ST_HALT);
endmodule

// File: rtl/spi_mem_cmd_frontend.sv
module spi_mem_cmd_frontend
  import cmdfe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       serClk,
  input  logic       serIn,
  input  logic       wpN,
  input  logic       lastDataBit,
  input  logic       progBusy,
  output logic       serOut,
  output logic       serOutEn,
  output logic       execStb,
  output logic [2:0] opKind,
  output logic       addrMsb,
  output logic       wel,
  output logic       progPermit,
  output logic       progStart,
  output logic       devSelected
);
  dpStrobe_t       strobe;
  opKind_e         decOp;
  logic            decAddr;
  opKind_e         opKindQ;
  logic [OP_W-1:0] statusWord;

  assign statusWord = {{(OP_W-2){1'b0}}, wel, progBusy};

  cmdfe_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .selN        (selN),
    .serClk      (serClk),
    .wpN         (wpN),
    .lastDataBit (lastDataBit),
    .decOp       (decOp),
    .decAddr     (decAddr),
    .strobe      (strobe),
    .execStb     (execStb),
    .opKind      (opKindQ),
    .addrMsb     (addrMsb),
    .wel         (wel),
    .progStart   (progStart),
    .serOutEn    (serOutEn),
    .devSelected (devSelected)
  );

  cmdfe_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .serIn      (serIn),
    .statusWord (statusWord),
    .decOp      (decOp),
    .decAddr    (decAddr),
    .serOut     (serOut)
  );

  assign opKind     = opKindQ;
  assign progPermit = wel & wpN;
endmodule

// File: rtl/cmdfe_checker.sv
module cmdfe_checker
  import cmdfe_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       selN,
  input logic       wpN,
  input logic       serOutEn,
  input logic       execStb,
  input logic [2:0] opKind,
  input logic       addrMsb,
  input logic       wel,
  input logic       progStart,
  input logic       devSelected
);
  a_r2_exec_single: assert property (@(posedge clk) disable iff (!rstN)
    execStb |=> !execStb);

  a_r4_addr_array_only: assert property (@(posedge clk) disable iff (!rstN)
    addrMsb |-> (opKind == OP_READ || opKind == OP_WRITE));

  a_r5_halt_no_exec: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !devSelected) |=> !execStb);

  a_r6_wren_sets: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && opKind == OP_WREN && $past(wpN)) |-> wel);

  a_r6_wrdi_clears: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && opKind == OP_WRDI) |-> !wel);

  a_r8_wp_clears: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> !wel);

  a_r9_prog_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> ($past(wel) && $past(wpN)));

  a_r12_oe_off_deselected: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> !serOutEn);

  a_r12_oe_status_only: assert property (@(posedge clk) disable iff (!rstN)
    serOutEn |-> (opKind == OP_RDSR));
endmodule

bind spi_mem_cmd_frontend cmdfe_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .selN        (selN),
  .wpN         (wpN),
  .serOutEn    (serOutEn),
  .execStb     (execStb),
  .opKind      (opKind),
  .addrMsb     (addrMsb),
  .wel         (wel),
  .progStart   (progStart),
  .devSelected (devSelected)
);

// File: tb/spi_mem_cmd_frontend_tb.sv
module spi_mem_cmd_frontend_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selN = 1'b1;
  logic       serClk = 1'b0;
  logic       serIn = 1'b0;
  logic       wpN = 1'b1;
  logic       lastDataBit = 1'b0;
  logic       progBusy = 1'b0;
  logic       serOut, serOutEn, execStb, addrMsb, wel, progPermit, progStart, devSelected;
  logic [2:0] opKind;

  int nChecks = 0;
  int nErr = 0;
  int execCnt = 0;
  int progCnt = 0;
  logic [2:0] lastOp = 3'd0;
  logic lastAddr = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_mem_cmd_frontend u_dut (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk), .serIn(serIn),
    .wpN(wpN), .lastDataBit(lastDataBit), .progBusy(progBusy),
    .serOut(serOut), .serOutEn(serOutEn), .execStb(execStb), .opKind(opKind),
    .addrMsb(addrMsb), .wel(wel), .progPermit(progPermit),
    .progStart(progStart), .devSelected(devSelected)
  );

  always @(negedge clk) begin
    if (execStb) begin
      execCnt++;
      lastOp   = opKind;
      lastAddr = addrMsb;
    end
    if (progStart) progCnt++;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      serIn = b[i];
      tick(2);
      serClk = 1'b1;
      tick(2);
      serClk = 1'b0;
      tick(2);
    end
  endtask

  task automatic selectDev();
    selN = 1'b0;
    tick(2);
  endtask

  task automatic deselectDev();
    selN = 1'b1;
    tick(3);
  endtask

  task automatic runOp(input logic [7:0] b);
    selectDev();
    sendBits(b, 8);
    tick(2);
    deselectDev();
  endtask

  task automatic pulseLast();
    lastDataBit = 1'b1;
    tick(1);
    lastDataBit = 1'b0;
    tick(3);
  endtask

  // Expected decode from R3, bit 3 masked
  function automatic logic [2:0] expKind(input logic [7:0] b);
    case (b & 8'hF7)
      8'h06: return 3'd1;
      8'h04: return 3'd2;
      8'h05: return 3'd3;
      8'h01: return 3'd4;
      8'h03: return 3'd5;
      8'h02: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic expWel;
    int e0, p0;
    tick(3);
    // R1: reset state
    chk(wel == 0 && execStb == 0 && progStart == 0 && serOutEn == 0 && opKind == 0,
        "R1 reset outputs", {wel, execStb, progStart, serOutEn}, 0);
    rstN = 1'b1;
    tick(3);

    // R2 R3 R4 R5 R6: exhaustive opcode sweep
    expWel = 1'b0;
    for (int op = 0; op < 256; op++) begin
      logic [7:0] b;
      logic [2:0] k;
      logic expA;
      b = 8'(op);
      k = expKind(b);
      expA = b[3] && (k == 3'd5 || k == 3'd6);
      e0 = execCnt;
      selectDev();
      sendBits(b, 8);
      tick(2);
      if (k != 0) begin
        chk(execCnt == e0 + 1, "R2 single exec pulse", execCnt - e0, 1);
        chk(lastOp == k, "R3 decoded kind at strobe", lastOp, k);
        chk(opKind == k, "R2 kind held", opKind, k);
        chk(lastAddr == expA && addrMsb == expA, "R4 address msb", addrMsb, expA);
        chk(devSelected == 1, "R5 valid stays selected", devSelected, 1);
      end else begin
        chk(execCnt == e0, "R5 no exec on invalid", execCnt - e0, 0);
        chk(devSelected == 0, "R5 internal deselect", devSelected, 1'b0);
      end
      if (k == 3'd1) expWel = 1'b1;
      if (k == 3'd2) expWel = 1'b0;
      chk(wel == expWel, "R6 latch after opcode", wel, expWel);
      chk(serOutEn == (k == 3'd3), "R12 oe only for status", serOutEn, k == 3'd3);
      deselectDev();
      chk(serOutEn == 0, "R12 oe off when deselected", serOutEn, 0);
    end

    // R5: clocks ignored after invalid opcode
    runOp(8'h04);
    e0 = execCnt;
    selectDev();
    sendBits(8'hFF, 8);
    sendBits(8'h06, 8);
    tick(2);
    chk(execCnt == e0 && wel == 0, "R5 halted ignores WREN", execCnt - e0, 0);
    deselectDev();
    runOp(8'h06);
    chk(wel == 1, "R5 works after reselect", wel, 1);

    // R7: wait after WREN/WRDI
    e0 = execCnt;
    selectDev();
    sendBits(8'h06, 8);
    sendBits(8'h04, 8);
    tick(2);
    chk(execCnt == e0 + 1, "R7 second byte ignored", execCnt - e0, 1);
    chk(wel == 1, "R7 latch kept", wel, 1);
    deselectDev();
    selectDev();
    sendBits(8'h04, 8);
    sendBits(8'h06, 8);
    tick(2);
    chk(wel == 0, "R7 WREN ignored after WRDI", wel, 0);
    deselectDev();

    // R13: partial opcode discarded
    e0 = execCnt;
    selectDev();
    sendBits(8'hF0, 4);
    deselectDev();
    selectDev();
    sendBits(8'h06, 8);
    tick(2);
    chk(execCnt == e0 + 1 && lastOp == 3'd1, "R13 fresh byte decoded", lastOp, 1);
    deselectDev();

    // R8: write protect
    chk(progPermit == 1, "R8 permit when latch and wp high", progPermit, 1);
    wpN = 1'b0;
    tick(2);
    chk(wel == 0 && progPermit == 0, "R8 wp clears latch", wel, 0);
    runOp(8'h06);
    chk(wel == 0, "R8 WREN blocked under wp", wel, 0);
    wpN = 1'b1;
    tick(2);

    // R9: program start with latch, both write kinds
    for (int v = 0; v < 3; v++) begin
      logic [7:0] opc;
      opc = (v == 0) ? 8'h02 : (v == 1) ? 8'h0A : 8'h01;
      runOp(8'h06);
      p0 = progCnt;
      selectDev();
      sendBits(opc, 8);
      tick(2);
      pulseLast();
      chk(progCnt == p0 + 1, "R9 single progStart", progCnt - p0, 1);
      chk(wel == 0, "R9 latch cleared after write", wel, 0);
      deselectDev();
    end
    p0 = progCnt;
    selectDev();
    sendBits(8'h02, 8);
    tick(2);
    pulseLast();
    chk(progCnt == p0, "R9 no start without latch", progCnt - p0, 0);
    deselectDev();

    // R10: late write protect cancels
    runOp(8'h06);
    p0 = progCnt;
    selectDev();
    sendBits(8'h02, 8);
    wpN = 1'b0;
    tick(2);
    wpN = 1'b1;
    tick(2);
    pulseLast();
    chk(progCnt == p0 && wel == 0, "R10 cancelled program", progCnt - p0, 0);
    deselectDev();

    // R14: read kinds ignore lastDataBit
    for (int v = 0; v < 2; v++) begin
      runOp(8'h06);
      p0 = progCnt;
      selectDev();
      sendBits(v == 0 ? 8'h03 : 8'h05, 8);
      tick(2);
      pulseLast();
      chk(progCnt == p0 && wel == 1, "R14 no program on read", progCnt - p0, 0);
      deselectDev();
    end

    // R11: status read bit stream
    for (int v = 0; v < 2; v++) begin
      logic [7:0] st;
      if (v == 0) begin
        progBusy = 1'b1;
        runOp(8'h06);
      end else begin
        progBusy = 1'b0;
        runOp(8'h04);
      end
      st = {6'b0, wel, progBusy};
      chk(st == (v == 0 ? 8'h03 : 8'h00), "R11 status setup", st, v == 0 ? 3 : 0);
      selectDev();
      sendBits(8'h05, 8);
      tick(1);
      chk(serOutEn == 1, "R12 oe during status", serOutEn, 1);
      for (int k = 0; k < 16; k++) begin
        logic expB;
        expB = st[7 - (k % 8)];
        chk(serOut == expB, "R11 status bit", serOut, expB);
        serClk = 1'b1;
        tick(2);
        serClk = 1'b0;
        tick(2);
      end
      deselectDev();
      chk(serOutEn == 0, "R12 oe off after status", serOutEn, 0);
    end
    progBusy = 1'b0;

    done = 1'b1;
    finishRun();
  end
endmodule